// File: doc/BRIEF.md
# 8b/10b Receive Character Decoder with Raw Bypass

This block sits behind a deserializer on the receive side of a serial link. Each clock it takes one 10-bit code group. In normal operation it maps the group back to its 8-bit byte and raises a control flag for the twelve special characters. It also tracks running disparity from group to group. Two separate error flags mark groups that are not legal codes and groups whose disparity is wrong for the current running disparity.

The data byte, control flag and both error flags come out of a single register stage, so they all describe the same group in the same cycle. A raw-enable input bypasses decoding for link testing. The undecoded group then goes straight to the output registers, the error checks are silenced and running disparity is frozen. The reset is synchronous and active high, and it belongs to the receive clock domain.

Top module: `rx_dec10b`

## Requirements
- R1: While `rst` is high, every output reads zero at the next clock edge, and running disparity restarts negative.
- R2: `code_in[9:4]` holds the 6-bit sub-block abcdei with a in bit 9, and `code_in[3:0]` holds the 4-bit sub-block fghj with f in bit 3. One clock after a legal data group is presented, `data_out` = {HGF, EDCBA} = {3-bit value, 5-bit value} and `ctrl_out` = 0.
- R3: A stream whose groups use the form matching the tracked running disparity (negative form while negative, the alternate form while positive) decodes with both error flags low.
- R4: The twelve control characters assert `ctrl_out` with `data_out` = {y, x}. These are K28.0 to K28.7 (6-bit 001111 or 110000) and K23.7, K27.7, K29.7, K30.7, which use the alternate-7 4-bit form. K28.5 gives 8'hBC.
- R5: `bad_code` rises for a group that has any of these faults: a 6-bit sub-block outside the code table; a 4-bit sub-block of 0000 or 1111; a 4-bit sub-block after 001111/110000 that is not a control pattern; 1110 after e,i = 1,1 or 0001 after e,i = 0,0; 0111 other than after e,i = 1,1 (or a K23/27/29/30 sub-block); 1000 other than after e,i = 0,0 (or such a sub-block).
- R6: `disp_err` rises when a sub-block with more ones arrives at positive disparity, or one with more zeros arrives at negative disparity. It also rises for 111000 or 1100 at positive disparity, and for 000111 or 0011 at negative disparity. The 6-bit sub-block is judged first and the 4-bit sub-block against the disparity it leaves.
- R7: Running disparity is updated from every normal-mode group, including groups that raise an error flag.
- R8: A group that is both illegal and wrong in disparity raises both flags in the same cycle.
- R9: With `raw_en` high, the next cycle shows `raw_out` = the group, `data_out` = `code_in[7:0]`, and `ctrl_out`, `bad_code` and `disp_err` all low.
- R10: Groups received with `raw_en` high leave running disparity unchanged.
- R11: In normal mode too, `raw_out` carries the group received one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_en | input | 1 | Bypass decoding and checks |
| code_in | input | 10 | Incoming code group, abcdei in [9:4], fghj in [3:0] |
| data_out | output | 8 | Decoded byte, or low bits of the group in raw mode |
| ctrl_out | output | 1 | Group was a control character |
| raw_out | output | 10 | Registered undecoded group |
| bad_code | output | 1 | Group is not a legal code |
| disp_err | output | 1 | Group violated running disparity |

## Verification
The bench sends all 256 data bytes with its own encoder, so running disparity swings both ways and the alternate-7 placements appear. A decoder with a wrong table entry or a wrong disparity rule would raise a false flag or return a wrong byte there. It sends the twelve control characters from both disparities; a decoder that mishandles the complemented K28 tail would misname K28.1, K28.2, K28.5 or K28.6 on one side. Errored groups that move disparity are followed by a group that is legal only under the updated value, which exposes a tracker that skips errored groups. The same probe run after raw traffic exposes a tracker that moves in bypass.

// File: rtl/dec10b_pkg.sv
package dec10b_pkg;
  localparam int SIX_W   = 6;
  localparam int FOUR_W  = 4;
  localparam int GROUP_W = SIX_W + FOUR_W;
  localparam int LO_W    = 5;
  localparam int HI_W    = 3;
  localparam int BYTE_W  = LO_W + HI_W;
  localparam int LO_N    = 1 << LO_W;

  localparam logic [SIX_W-1:0]  SIX_K28  = 6'b001111;
  localparam logic [SIX_W-1:0]  SIX_BAL_P = 6'b000111;
  localparam logic [SIX_W-1:0]  SIX_BAL_N = 6'b111000;
  localparam logic [FOUR_W-1:0] FOUR_BAL_P = 4'b0011;
  localparam logic [FOUR_W-1:0] FOUR_BAL_N = 4'b1100;

  typedef enum logic { RD_NEG = 1'b0, RD_POS = 1'b1 } rd_e;

  typedef struct packed {
    logic err;
    rd_e  nxt;
  } rd_step_t;

  // 6-bit form sent when running disparity is negative, per 5-bit value.
  function automatic logic [SIX_W-1:0] six_neg_form(input logic [LO_W-1:0] v);
    case (v)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // A value has a complemented positive-disparity form when its negative
  // form is unbalanced, or when it is the balanced-but-directional 111000.
  function automatic logic six_has_alt(input logic [LO_W-1:0] v);
    return ($countones(six_neg_form(v)) != 3) || (six_neg_form(v) == SIX_BAL_N);
  endfunction

  function automatic rd_step_t rd_step6(input logic [SIX_W-1:0] blk, input rd_e rd);
    rd_step_t s;
    int n;
    n = $countones(blk);
    s.err = 1'b0;
    s.nxt = rd;
    if (blk == SIX_BAL_P) begin
      s.err = (rd == RD_NEG); s.nxt = RD_POS;
    end else if (blk == SIX_BAL_N) begin
      s.err = (rd == RD_POS); s.nxt = RD_NEG;
    end else if (n > SIX_W / 2) begin
      s.err = (rd == RD_POS); s.nxt = RD_POS;
    end else if (n < SIX_W / 2) begin
      s.err = (rd == RD_NEG); s.nxt = RD_NEG;
    end
    return s;
  endfunction

  function automatic rd_step_t rd_step4(input logic [FOUR_W-1:0] blk, input rd_e rd);
    rd_step_t s;
    int n;
    n = $countones(blk);
    s.err = 1'b0;
    s.nxt = rd;
    if (blk == FOUR_BAL_P) begin
      s.err = (rd == RD_NEG); s.nxt = RD_POS;
    end else if (blk == FOUR_BAL_N) begin
      s.err = (rd == RD_POS); s.nxt = RD_NEG;
    end else if (n > FOUR_W / 2) begin
      s.err = (rd == RD_POS); s.nxt = RD_POS;
    end else if (n < FOUR_W / 2) begin
      s.err = (rd == RD_NEG); s.nxt = RD_NEG;
    end
    return s;
  endfunction
endpackage

// File: rtl/dec10b_six.sv
module dec10b_six
  import dec10b_pkg::*;
(
  input  logic [SIX_W-1:0] six,
  output logic [LO_W-1:0]  val5,
  output logic             ok,
  output logic             k28,
  output logic             k28_inv,
  output logic             kx7
);
  always_comb begin
    val5 = '0;
    ok   = 1'b0;
    for (int v = 0; v < LO_N; v++) begin
      if ((six == six_neg_form(LO_W'(v))) ||
          (six_has_alt(LO_W'(v)) && (six == ~six_neg_form(LO_W'(v))))) begin
        val5 = LO_W'(v);
        ok   = 1'b1;
      end
    end
    k28     = (six == SIX_K28) || (six == ~SIX_K28);
    k28_inv = (six == ~SIX_K28);
    if (k28) begin
      val5 = LO_W'(28);
      ok   = 1'b1;
    end
    case (six)
      6'b111010, 6'b000101, 6'b110110, 6'b001001,
      6'b101110, 6'b010001, 6'b011110, 6'b100001: kx7 = 1'b1;
      default:                                    kx7 = 1'b0;
    endcase
  end
endmodule

// File: rtl/dec10b_four.sv
module dec10b_four
  import dec10b_pkg::*;
(
  input  logic [FOUR_W-1:0] four,
  input  logic              k28,
  input  logic              k28_inv,
  input  logic              kx7,
  input  logic [1:0]        tail_ei,
  output logic [HI_W-1:0]   val3,
  output logic              ok,
  output logic              ctrl
);
  logic [FOUR_W-1:0] norm;
  logic              alt7;
  logic              pri7;
  logic              pri7_run;
  logic              alt7_fit;

  always_comb begin
    norm = k28_inv ? ~four : four;
    val3 = '0;
    ok   = 1'b1;
    ctrl = 1'b0;
    alt7 = 1'b0;
    pri7 = 1'b0;
    if (k28) begin
      ctrl = 1'b1;
      case (norm)
        4'b0100: val3 = 3'd0;
        4'b1001: val3 = 3'd1;
        4'b0101: val3 = 3'd2;
        4'b0011: val3 = 3'd3;
        4'b0010: val3 = 3'd4;
        4'b1010: val3 = 3'd5;
        4'b0110: val3 = 3'd6;
        4'b1000: val3 = 3'd7;
        default: begin ok = 1'b0; ctrl = 1'b0; end
      endcase
    end else begin
      case (four)
        4'b1011, 4'b0100: val3 = 3'd0;
        4'b1001:          val3 = 3'd1;
        4'b0101:          val3 = 3'd2;
        4'b1100, 4'b0011: val3 = 3'd3;
        4'b1101, 4'b0010: val3 = 3'd4;
        4'b1010:          val3 = 3'd5;
        4'b0110:          val3 = 3'd6;
        4'b1110, 4'b0001: begin val3 = 3'd7; pri7 = 1'b1; end
        4'b0111, 4'b1000: begin val3 = 3'd7; alt7 = 1'b1; end
        default:          ok = 1'b0;
      endcase
    end
  end

  // Placement rules for the two forms of value 7.
  assign pri7_run = (four == 4'b1110 && tail_ei == 2'b11) ||
                    (four == 4'b0001 && tail_ei == 2'b00);
  assign alt7_fit = (four == 4'b0111 && tail_ei == 2'b11) ||
                    (four == 4'b1000 && tail_ei == 2'b00);

  logic ok_final;
  logic ctrl_final;
  always_comb begin
    ok_final   = ok;
    ctrl_final = ctrl;
    if (pri7 && pri7_run) ok_final = 1'b0;
    if (alt7) begin
      if (kx7)            ctrl_final = 1'b1;
      else if (!alt7_fit) ok_final   = 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = ok_final;
endmodule

// File: rtl/dec10b_disp.sv
module dec10b_disp
  import dec10b_pkg::*;
(
  input  logic [SIX_W-1:0]  six,
  input  logic [FOUR_W-1:0] four,
  input  rd_e               rd_in,
  output logic              err6,
  output logic              err4,
  output rd_e               rd_out
);
  rd_step_t s6;
  rd_step_t s4;

  always_comb begin
    s6     = rd_step6(six, rd_in);
    s4     = rd_step4(four, s6.nxt);
    err6   = s6.err;
    err4   = s4.err;
    rd_out = s4.nxt;
  end
endmodule

// File: rtl/rx_dec10b.sv
module rx_dec10b
  import dec10b_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               raw_en,
  input  logic [GROUP_W-1:0] code_in,
  output logic [BYTE_W-1:0]  data_out,
  output logic               ctrl_out,
  output logic [GROUP_W-1:0] raw_out,
  output logic               bad_code,
  output logic               disp_err
);
  logic [SIX_W-1:0]  six;
  logic [FOUR_W-1:0] four;
  assign six  = code_in[GROUP_W-1:FOUR_W];
  assign four = code_in[FOUR_W-1:0];

  logic [LO_W-1:0] val5;
  logic [HI_W-1:0] val3;
  logic six_ok, four_ok, k28, k28_inv, kx7, ctrl_hit;
  logic err6, err4;
  rd_e  rd_q, rd_next;

  dec10b_six u_six (
    .six(six), .val5(val5), .ok(six_ok),
    .k28(k28), .k28_inv(k28_inv), .kx7(kx7)
  );

  dec10b_four u_four (
    .four(four), .k28(k28), .k28_inv(k28_inv), .kx7(kx7),
    .tail_ei(six[1:0]), .val3(val3), .ok(four_ok), .ctrl(ctrl_hit)
  );

  dec10b_disp u_disp (
    .six(six), .four(four), .rd_in(rd_q),
    .err6(err6), .err4(err4), .rd_out(rd_next)
  );

  // Named events for the checks below.
  logic grp_bad, grp_derr, grp_ctrl;
  assign grp_bad  = !(six_ok && u_four.ok_final);
  assign grp_derr = err6 || err4;
  assign grp_ctrl = u_four.ctrl_final && !grp_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      ctrl_out <= 1'b0;
      raw_out  <= '0;
      bad_code <= 1'b0;
      disp_err <= 1'b0;
      rd_q     <= RD_NEG;
    end else begin
      raw_out <= code_in;
      if (raw_en) begin
        data_out <= code_in[BYTE_W-1:0];
        ctrl_out <= 1'b0;
        bad_code <= 1'b0;
        disp_err <= 1'b0;
      end else begin
        data_out <= {val3, val5};
        ctrl_out <= grp_ctrl;
        bad_code <= grp_bad;
        disp_err <= grp_derr;
        rd_q     <= rd_next;
      end
    end
  end

  logic unused_four_ok, unused_ctrl;
  assign unused_four_ok = four_ok;
  assign unused_ctrl    = ctrl_hit;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (data_out == '0 && !ctrl_out && raw_out == '0 && !bad_code && !disp_err));

  assert_raw_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(raw_en) |-> (!ctrl_out && !bad_code && !disp_err));

  assert_raw_follow_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> raw_out == $past(code_in));

  assert_rd_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(raw_en)) |-> rd_q == $past(rd_q));

  assert_ctrl_value_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_out |-> (data_out[LO_W-1:0] == LO_W'(28) || data_out[BYTE_W-1:LO_W] == HI_W'(7)));
endmodule

// File: tb/rx_dec10b_bench.sv
module rx_dec10b_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_en = 1'b0;
  logic [9:0] code_in = '0;
  logic [7:0] data_out;
  logic       ctrl_out, bad_code, disp_err;
  logic [9:0] raw_out;

  rx_dec10b u_rx_dec10b (
    .clk(clk), .rst(rst), .raw_en(raw_en), .code_in(code_in),
    .data_out(data_out), .ctrl_out(ctrl_out), .raw_out(raw_out),
    .bad_code(bad_code), .disp_err(disp_err)
  );

  always #4 clk = ~clk;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;
  bit  brd = 0; // bench running disparity, 1 = positive

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All outputs packed: raw, data, ctrl, bad, derr.
  function automatic logic [31:0] outs();
    return {11'd0, raw_out, data_out, ctrl_out, bad_code, disp_err};
  endfunction
  function automatic logic [31:0] want(logic [9:0] r, logic [7:0] d, bit c, bit b, bit e);
    return {11'd0, r, d, c, b, e};
  endfunction

  task automatic send(input logic [9:0] c);
    code_in = c;
    @(negedge clk);
  endtask

  function automatic logic [5:0] tab6(input int x);
    case (x)
      0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;  3: return 6'b110001;
      4: return 6'b110101;  5: return 6'b101001;  6: return 6'b011001;  7: return 6'b111000;
      8: return 6'b111001;  9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
     12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100; 15: return 6'b010111;
     16: return 6'b011011; 17: return 6'b100011; 18: return 6'b010011; 19: return 6'b110010;
     20: return 6'b001011; 21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
     24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110; 27: return 6'b110110;
     28: return 6'b001110; 29: return 6'b101110; 30: return 6'b011110; default: return 6'b101011;
    endcase
  endfunction

  function automatic bit alt6(input int x);
    case (x)
      0, 1, 2, 4, 7, 8, 15, 16, 23, 24, 27, 29, 30, 31: return 1;
      default: return 0;
    endcase
  endfunction

  // 4-bit tail for value y at disparity r; force_a picks the alternate 7.
  function automatic logic [3:0] tab4(input int y, input bit r, input bit force_a);
    logic [3:0] base;
    case (y)
      0: base = 4'b1011; 1: base = 4'b1001; 2: base = 4'b0101; 3: base = 4'b1100;
      4: base = 4'b1101; 5: base = 4'b1010; 6: base = 4'b0110;
      default: base = force_a ? 4'b0111 : 4'b1110;
    endcase
    if (r && (y == 0 || y == 3 || y == 4 || y == 7)) base = ~base;
    return base;
  endfunction

  task automatic enc_data(input int x, input int y, output logic [9:0] c);
    logic [5:0] s;
    bit a7;
    s = tab6(x);
    if (brd && alt6(x)) s = ~s;
    if (alt6(x) && x != 7) brd = ~brd;
    a7 = (y == 7) && ((!brd && (x == 17 || x == 18 || x == 20)) ||
                      (brd && (x == 11 || x == 13 || x == 14)));
    c = {s, tab4(y, brd, a7)};
    if (y == 0 || y == 4 || y == 7) brd = ~brd;
  endtask

  task automatic enc_ctrl(input int x, input int y, output logic [9:0] c);
    logic [5:0] s;
    logic [3:0] f;
    s = (x == 28) ? 6'b001111 : tab6(x);
    if (brd) s = ~s;
    brd = ~brd;
    f = tab4(y, brd, y == 7);
    if (x == 28 && !brd && (y == 1 || y == 2 || y == 5 || y == 6)) f = ~f;
    c = {s, f};
    if (y == 0 || y == 4 || y == 7) brd = ~brd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; raw_en = 1'b0; code_in = 10'h155;
    repeat (2) @(negedge clk);
    check("R1 reset state", outs(), want(10'h000, 8'h00, 0, 0, 0));
    rst = 1'b0;
    brd = 0;
  endtask

  task automatic t_data_sweep();
    logic [9:0] c;
    do_reset();
    for (int b = 0; b < 256; b++) begin
      enc_data(b % 32, b / 32, c);
      send(c);
      check($sformatf("R2 R3 R11 byte %02h", b), outs(), want(c, 8'(b), 0, 0, 0));
    end
  endtask

  task automatic t_ctrl();
    logic [9:0] c;
    do_reset();
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 12; k++) begin
        int x, y;
        x = (k < 8) ? 28 : (k == 8 ? 23 : (k == 9 ? 27 : (k == 10 ? 29 : 30)));
        y = (k < 8) ? k : 7;
        enc_ctrl(x, y, c);
        send(c);
        check($sformatf("R4 K%0d.%0d", x, y), outs(), want(c, 8'((y << 5) | x), 1, 0, 0));
      end
    end
  endtask

  task automatic t_invalid();
    do_reset();
    send({6'b110111, 4'b1001});
    check("R5 six-bit not in table", {29'd0, ctrl_out, bad_code, disp_err}, 32'b010);
    send({6'b110001, 4'b0000});
    check("R5 four-bit 0000", {29'd0, ctrl_out, bad_code, disp_err}, 32'b010);
    send({6'b100011, 4'b1110});
    check("R5 1110 after ei 11", {29'd0, ctrl_out, bad_code, disp_err}, 32'b010);
    send({6'b110001, 4'b1000});
    check("R5 1000 after ei 01", {29'd0, ctrl_out, bad_code, disp_err}, 32'b010);
    send({6'b001111, 4'b1110});
    check("R8 bad K28 tail with disparity fault", {29'd0, ctrl_out, bad_code, disp_err}, 32'b011);
  endtask

  task automatic t_disp();
    do_reset();
    send({6'b011000, 4'b1001});
    check("R6 negative six at negative rd", outs(), want({6'b011000, 4'b1001}, 8'h20, 0, 0, 1));
    send({6'b011000, 4'b1011});
    check("R6 errored group that raises rd", outs(), want({6'b011000, 4'b1011}, 8'h00, 0, 0, 1));
    send({6'b100111, 4'b1001});
    check("R7 rd moved by errored group", outs(), want({6'b100111, 4'b1001}, 8'h20, 0, 0, 1));
    send({6'b111000, 4'b1001});
    check("R6 111000 at positive rd", outs(), want({6'b111000, 4'b1001}, 8'h27, 0, 0, 1));
    send({6'b000111, 4'b0011});
    check("R6 000111 at negative rd", outs(), want({6'b000111, 4'b0011}, 8'h67, 0, 0, 1));
    send({6'b110001, 4'b1100});
    check("R6 1100 at positive rd", outs(), want({6'b110001, 4'b1100}, 8'h63, 0, 0, 1));
    send({6'b100111, 4'b1001});
    check("R3 clean group after errors", outs(), want({6'b100111, 4'b1001}, 8'h20, 0, 0, 0));
  endtask

  task automatic t_raw();
    do_reset();
    raw_en = 1'b1;
    send(10'h3FF);
    check("R9 raw all ones", outs(), want(10'h3FF, 8'hFF, 0, 0, 0));
    send(10'h000);
    check("R9 raw all zeros", outs(), want(10'h000, 8'h00, 0, 0, 0));
    send(10'h2AB);
    check("R9 raw pattern", outs(), want(10'h2AB, 8'hAB, 0, 0, 0));
    send({6'b001111, 4'b1010});
    check("R9 raw control group not flagged", outs(), want(10'h0FA, 8'hFA, 0, 0, 0));
    send({6'b001111, 4'b1110});
    check("R9 raw faulty group not flagged", outs(), want(10'h0FE, 8'hFE, 0, 0, 0));
    raw_en = 1'b0;
    send({6'b100111, 4'b1001});
    check("R10 rd unchanged by raw traffic", outs(), want({6'b100111, 4'b1001}, 8'h20, 0, 0, 0));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_data_sweep();
    t_ctrl();
    t_invalid();
    t_disp();
    t_raw();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule